// File: doc/BRIEF.md
# Half-Step Programmable Clock Divider

This block derives a slower clock from a fast reference. The divided clock is also produced as a one-cycle enable, so downstream logic can stay on the fast clock if it prefers. The division ratio is picked from a fixed list of 22 values between 1.5 and 16, and the list includes every half step up to 8. The block runs on a single clock edge. Its clock `clk` runs at twice the reference frequency, so one `clk` cycle is half a reference period, and a ratio R gives an output period of N = 2R cycles of `clk`.

The output stays low until `lock_in` is asserted. While `lock_in` is high, the block cycles through a high phase and a low phase. The lengths of these phases are fixed at the start of each output period from the ratio code and the mode input:

- **Even N:** the duty cycle is exactly 50%.
- **Odd N, low-frequency mode:** the two phase lengths swap from one period to the next, so the average duty cycle is 50%.
- **Odd N, high-frequency mode:** every period has the short high phase.

If `lock_in` falls, the output drops and all internal timing restarts.

The core is a three-state machine:

- **IDLE** (not locked).
- **HIGH** (output high).
- **LOW** (output low).

Its transitions are:

- **lock** (IDLE to HIGH, when `lock_in` is sampled high).
- **fall** (HIGH to LOW, when the high-phase count runs out).
- **wrap** (LOW to HIGH, when the low-phase count runs out; this starts a new period).
- **drop** (any state to IDLE, when `lock_in` is sampled low).

Top module: `hdiv_clken`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises with `lock_in` low, both `div_out` and `tick_out` are 0.
- R2: The ratio code selects a period of N `clk` cycles:
  - codes 0 to 13 give N = code + 3 (ratios 1.5 to 8 in half steps);
  - codes 14 to 21 give N = 2 × (code − 5) (ratios 9 to 16);
  - codes 22 to 31 give N = 4 (ratio 2).
- R3: For even N, each period has N/2 cycles high followed by N/2 cycles low.
- R4: For odd N with `hf_mode` = 0, the first period after lock is high for floor(N/2) cycles and low for ceil(N/2) cycles. The following period is high for ceil(N/2) and low for floor(N/2), and the two patterns keep alternating.
- R5: For odd N with `hf_mode` = 1, every period is high for floor(N/2) cycles and low for ceil(N/2) cycles.
- R6: `div_out` never rises while `lock_in` is low. When `lock_in` is first sampled high by a rising edge of `clk`, `div_out` is 1 right after that edge.
- R7: When `lock_in` is sampled low, `div_out` and `tick_out` are 0 after that edge. On the next lock, timing restarts from the first period of R4, with a full high phase.
- R8: A new `ratio_code` or `hf_mode` value takes effect only at the next rising edge of `div_out`. The period already in progress finishes with its original phase lengths.
- R9: `tick_out` is 1 exactly in the cycle where `div_out` rises, and it is 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the reference frequency |
| rst_n | input | 1 | Asynchronous active-low reset |
| lock_in | input | 1 | Upstream lock; the output runs only while high |
| hf_mode | input | 1 | 1 selects high-frequency duty behaviour for odd N |
| ratio_code | input | 5 | Division ratio selector |
| div_out | output | 1 | Divided clock |
| tick_out | output | 1 | One-cycle enable at each rising edge of `div_out` |

## Verification
The bench builds the block with its default parameters: a 5-bit code, a 6-bit length field, 14 half-step codes and 8 whole-step codes. With this configuration, all 32 codes can be swept in both modes. The sweep covers:

- every legal ratio;
- the unused codes that fall back to a ratio of 2;
- the shortest odd period, N = 3, where the high phase shrinks to a single cycle.

Each sweep entry drops and re-acquires lock and then compares three full periods cycle by cycle against an arithmetic model. Directed runs cover three further cases:

- changing the code in mid-period, both during a high phase and during a low phase;
- changing the mode at the same time as the code;
- losing lock partway through the long-high half of an odd cycle pair, then re-acquiring it.

// File: rtl/hdiv_pkg.sv
package hdiv_pkg;

    // Phase state of the divider core.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HIGH = 2'd1,
        ST_LOW  = 2'd2
    } hdiv_state_e;

endpackage

// File: rtl/hdiv_ratio_decode.sv
module hdiv_ratio_decode #(
    parameter int CODE_W          = 5,
    parameter int LEN_W           = 6,
    parameter int HALF_STEPS      = 14,
    parameter int WHOLE_STEPS     = 8,
    parameter int FALLBACK_HALVES = 4
) (
    input  logic [CODE_W-1:0] code_i,
    output logic [LEN_W-1:0]  halves_o
);
    localparam int N_CODES     = 2 ** CODE_W;
    localparam int FIRST_HALF  = 3;
    localparam int FIRST_WHOLE = HALF_STEPS + FIRST_HALF + 1;
    localparam int LAST_LEGAL  = HALF_STEPS + WHOLE_STEPS;

    logic [LEN_W-1:0] table_q [N_CODES];

    // Period length in half-reference cycles, computed per code.
    for (genvar i = 0; i < N_CODES; i++) begin : g_entry
        localparam int HALVES =
            (i < HALF_STEPS) ? (i + FIRST_HALF) :
            (i < LAST_LEGAL) ? (FIRST_WHOLE + 2 * (i - HALF_STEPS)) :
                               FALLBACK_HALVES;
        assign table_q[i] = LEN_W'(HALVES);
    end

    assign halves_o = table_q[code_i];

endmodule

// File: rtl/hdiv_phase_split.sv
module hdiv_phase_split #(
    parameter int LEN_W = 6
) (
    input  logic [LEN_W-1:0] halves_i,
    input  logic             hf_mode_i,
    input  logic             parity_i,
    output logic [LEN_W-1:0] hi_len_o,
    output logic [LEN_W-1:0] lo_len_o
);
    logic [LEN_W-1:0] short_len;
    logic [LEN_W-1:0] long_len;
    logic             use_long;

    always_comb begin
        short_len = halves_i >> 1;
        long_len  = halves_i - short_len;
        // Odd period, low-frequency mode, odd-numbered period: long high.
        use_long  = halves_i[0] && !hf_mode_i && parity_i;
        hi_len_o  = use_long ? long_len : short_len;
        lo_len_o  = halves_i - hi_len_o;
    end

endmodule

// File: rtl/hdiv_phase_fsm.sv
module hdiv_phase_fsm #(
    parameter int LEN_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lock_in,
    input  logic [LEN_W-1:0] plan_hi_i,
    input  logic [LEN_W-1:0] plan_lo_i,
    output logic             parity_o,
    output logic             div_o,
    output logic             tick_o
);
    import hdiv_pkg::*;

    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    hdiv_state_e      state_q, state_d;
    logic [LEN_W-1:0] cnt_q, cnt_d;
    logic [LEN_W-1:0] lo_q, lo_d;
    logic             par_q, par_d;
    logic             start_period;
    logic             div_q, tick_q;

    // Next-state logic: lock, fall, wrap and drop transitions.
    always_comb begin
        state_d      = state_q;
        cnt_d        = cnt_q;
        lo_d         = lo_q;
        par_d        = par_q;
        start_period = 1'b0;
        if (!lock_in) begin
            state_d = ST_IDLE;
            cnt_d   = '0;
            lo_d    = '0;
            par_d   = 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: start_period = 1'b1;
                ST_HIGH: begin
                    if (cnt_q == '0) begin
                        state_d = ST_LOW;
                        cnt_d   = lo_q - ONE;
                    end else begin
                        cnt_d = cnt_q - ONE;
                    end
                end
                ST_LOW: begin
                    if (cnt_q == '0) begin
                        start_period = 1'b1;
                    end else begin
                        cnt_d = cnt_q - ONE;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
            if (start_period) begin
                state_d = ST_HIGH;
                cnt_d   = plan_hi_i - ONE;
                lo_d    = plan_lo_i;
                par_d   = ~par_q;
            end
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            lo_q    <= '0;
            par_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            lo_q    <= lo_d;
            par_q   <= par_d;
        end
    end

    // Output register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q  <= 1'b0;
            tick_q <= 1'b0;
        end else begin
            div_q  <= (state_d == ST_HIGH);
            tick_q <= start_period;
        end
    end

    assign parity_o = par_q;
    assign div_o    = div_q;
    assign tick_o   = tick_q;

endmodule

// File: rtl/hdiv_clken.sv
module hdiv_clken #(
    parameter int CODE_W          = 5,
    parameter int LEN_W           = 6,
    parameter int HALF_STEPS      = 14,
    parameter int WHOLE_STEPS     = 8,
    parameter int FALLBACK_HALVES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lock_in,
    input  logic              hf_mode,
    input  logic [CODE_W-1:0] ratio_code,
    output logic              div_out,
    output logic              tick_out
);
    logic [LEN_W-1:0] halves;
    logic [LEN_W-1:0] hi_len;
    logic [LEN_W-1:0] lo_len;
    logic             parity;

    hdiv_ratio_decode #(
        .CODE_W         (CODE_W),
        .LEN_W          (LEN_W),
        .HALF_STEPS     (HALF_STEPS),
        .WHOLE_STEPS    (WHOLE_STEPS),
        .FALLBACK_HALVES(FALLBACK_HALVES)
    ) u_decode (
        .code_i  (ratio_code),
        .halves_o(halves)
    );

    hdiv_phase_split #(.LEN_W(LEN_W)) u_split (
        .halves_i (halves),
        .hf_mode_i(hf_mode),
        .parity_i (parity),
        .hi_len_o (hi_len),
        .lo_len_o (lo_len)
    );

    hdiv_phase_fsm #(.LEN_W(LEN_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .lock_in  (lock_in),
        .plan_hi_i(hi_len),
        .plan_lo_i(lo_len),
        .parity_o (parity),
        .div_o    (div_out),
        .tick_o   (tick_out)
    );

endmodule

// File: rtl/hdiv_checker.sv
module hdiv_checker #(
    parameter int MAX_HALVES = 32
) (
    input logic clk,
    input logic rst_n,
    input logic lock_in,
    input logic div_out,
    input logic tick_out
);
    localparam int MAX_HIGH = MAX_HALVES / 2;

    logic [7:0] high_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            high_run_q <= '0;
        end else if (!div_out) begin
            high_run_q <= '0;
        end else if (high_run_q != 8'hFF) begin
            high_run_q <= high_run_q + 8'd1;
        end
    end

    // R7: losing lock forces the output low on the next cycle.
    a_r7_drop_forces_low: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_in |=> (!div_out && !tick_out));

    // R6: a rising edge of div_out needs lock in the previous cycle.
    a_r6_rise_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(div_out) |-> $past(lock_in));

    // R9: every rising edge of div_out carries the enable pulse.
    a_r9_tick_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(div_out) |-> tick_out);

    // R9: the enable pulse appears only on a rising edge.
    a_r9_tick_only_rise: assert property (@(posedge clk) disable iff (!rst_n)
        tick_out |-> (div_out && !$past(div_out)));

    // R2: no high phase is longer than half the longest period.
    a_r2_high_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        div_out |-> (int'(high_run_q) < MAX_HIGH));

endmodule

bind hdiv_clken hdiv_checker #(.MAX_HALVES(32)) u_hdiv_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .lock_in (lock_in),
    .div_out (div_out),
    .tick_out(tick_out)
);

// File: tb/tb_hdiv_clken.sv
`timescale 1ns/1ps
module tb_hdiv_clken;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lock_in = 1'b0;
    logic       hf_mode = 1'b0;
    logic [4:0] ratio_code = '0;
    logic       div_out;
    logic       tick_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    hdiv_clken dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .lock_in   (lock_in),
        .hf_mode   (hf_mode),
        .ratio_code(ratio_code),
        .div_out   (div_out),
        .tick_out  (tick_out)
    );

    // R2: period length in clk cycles for a code.
    function automatic int exp_halves(int code);
        if (code < 14) return code + 3;
        if (code < 22) return 2 * (code - 5);
        return 4;
    endfunction

    // Expected {div, tick} at cycle j after lock: first period n0/h0, later n1/h1.
    function automatic bit [1:0] exp_out(int j, int n0, int n1, bit h0, bit h1);
        int pos = j;
        int p = 0;
        int n = n0;
        bit h = h0;
        int hi;
        while (pos >= n) begin
            pos = pos - n;
            p++;
            n = n1;
            h = h1;
        end
        hi = n / 2;
        if ((n % 2 == 1) && !h && (p % 2 == 1)) hi = n / 2 + 1;
        return {pos < hi, pos == 0};
    endfunction

    function automatic string cls(int n, bit h);
        if (n % 2 == 0) return "R3";
        if (!h) return "R4";
        return "R5";
    endfunction

    task automatic chk(string req, logic got, logic exp, string what);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0b expected %0b at %0t", req, what, got, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic run_cmp(string req, int from, int upto, int n0, int n1, bit h0, bit h1);
        for (int j = from; j < upto; j++) begin
            bit [1:0] e;
            step();
            e = exp_out(j, n0, n1, h0, h1);
            chk(req, div_out, e[1], "div_out");
            chk("R9", tick_out, e[0], "tick_out");
        end
    endtask

    task automatic unlock_set(int code, bit h);
        lock_in    = 1'b0;
        ratio_code = code[4:0];
        hf_mode    = h;
        step();
        chk("R7", div_out, 1'b0, "div_out after drop");
        lock_in = 1'b1;
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", div_out, 1'b0, "div_out in reset");
        chk("R1", tick_out, 1'b0, "tick_out in reset");
        rst_n = 1'b1;
        step();
        chk("R1", div_out, 1'b0, "div_out after reset");
        chk("R1", tick_out, 1'b0, "tick_out after reset");

        // R6: no activity while unlocked, whatever the code
        for (int c = 0; c < 8; c++) begin
            ratio_code = c[4:0];
            hf_mode = c[0];
            step();
            chk("R6", div_out, 1'b0, "div_out unlocked");
            chk("R6", tick_out, 1'b0, "tick_out unlocked");
        end
        ratio_code = 5'd3;
        hf_mode = 1'b0;
        lock_in = 1'b1;
        run_cmp("R6", 0, 12, 6, 6, 1'b0, 1'b0);

        // Sweep all codes in both modes (R2..R5)
        for (int c = 0; c < 32; c++) begin
            for (int h = 0; h < 2; h++) begin
                int n;
                string tag;
                n = exp_halves(c);
                tag = (c >= 22) ? "R2" : cls(n, h[0]);
                unlock_set(c, h[0]);
                run_cmp(tag, 0, 3 * n, n, n, h[0], h[0]);
            end
        end

        // R8: change during high phase, N=10 -> N=3 high-frequency
        unlock_set(7, 1'b0);
        run_cmp("R8", 0, 3, 10, 3, 1'b0, 1'b1);
        ratio_code = 5'd0;
        hf_mode = 1'b1;
        run_cmp("R8", 3, 19, 10, 3, 1'b0, 1'b1);

        // R8: change during low phase, N=7 -> N=20
        unlock_set(4, 1'b0);
        run_cmp("R8", 0, 5, 7, 20, 1'b0, 1'b0);
        ratio_code = 5'd15;
        run_cmp("R8", 5, 47, 7, 20, 1'b0, 1'b0);

        // R7: drop lock in the long-high period, relock restarts with short high
        unlock_set(2, 1'b0);
        run_cmp("R4", 0, 7, 5, 5, 1'b0, 1'b0);
        lock_in = 1'b0;
        step();
        chk("R7", div_out, 1'b0, "div_out after drop");
        chk("R7", tick_out, 1'b0, "tick_out after drop");
        step();
        chk("R7", div_out, 1'b0, "div_out held low");
        lock_in = 1'b1;
        run_cmp("R7", 0, 10, 5, 5, 1'b0, 1'b0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule